// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block picks the clock that drives the system from three candidates: a fast crystal, a fast RC oscillator and a low-power clock. The low-power clock is itself chosen from four slow sources by a separate select field. Software writes the two select fields and a crystal-disable bit through write strobes. The block exposes a glitch-free system clock and three one-hot status bits that name the source now in use.

Each change of source is a break-before-make handshake. The controller first asks the gate of the old source to close. That gate closes on a falling edge of its own clock, and the closure is reported back through a synchronizer. Only then does the controller ask the gate of the new source to open, again on that source's own falling edge. The status bits move when the new gate reports that it is open.

Interlocks stop software from breaking the clock tree. The crystal is not switched in until it is ready. The crystal cannot be disabled while it is in use. The low-power source cannot be changed while the low-power clock is in use.

Top module: `sysclk_switch`

## Requirements
- R1: After reset the system select reads 1, the low-power select reads 0, the crystal-disable bit reads 0, and only the RC status bit is set.
- R2: System select encoding: 0 selects the crystal, 1 selects the RC oscillator, and 2 and 3 both select the low-power clock. Once the switch settles, `sys_clk` runs at the period of the selected source.
- R3: Low-power select encoding: value k (0..3) routes `clk_lp_src[k]` to the low-power clock. With the system on the low-power clock, `sys_clk` takes that source's period.
- R4: A switch to the crystal is held off until `xtal_settled` or `xtal_trim_rdy` is 1 and the crystal-disable bit is 0. While held off, the present source keeps running.
- R5: A write that sets the crystal-disable bit is ignored while the crystal is the running source or the target of a switch in progress. A write of 0 is always taken.
- R6: A write to the low-power select is ignored while the low-power clock is the running source or the target of a switch in progress.
- R7: The status bits `{run_lp, run_rc, run_xtal}` are always one-hot. They keep their old value until the handshake completes, and they are unchanged at least 3 cycles after the select write.
- R8: At no time is more than one source gate open, and `sys_clk` carries no high pulse shorter than the shortest source half period.
- R9: A write to the system select is captured on the next `clk` edge and read back on `sys_sel_q`. The same holds for an accepted write to the other two fields.
- R10: Select changes made during a handshake are kept. After the handshake completes, the controller moves on to the latest selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for the select fields and the handshake |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Write strobe for the system select |
| sel_din | input | 2 | System select write data |
| lpsel_we | input | 1 | Write strobe for the low-power select |
| lpsel_din | input | LP_W | Low-power select write data |
| xoff_we | input | 1 | Write strobe for the crystal-disable bit |
| xoff_din | input | 1 | Crystal-disable write data |
| xtal_settled | input | 1 | Crystal settle time elapsed (asynchronous) |
| xtal_trim_rdy | input | 1 | Crystal trimming finished (asynchronous) |
| clk_xtal | input | 1 | Fast crystal clock |
| clk_rc | input | 1 | Fast RC clock |
| clk_lp_src | input | 2**LP_W | Low-power source clocks |
| sys_clk | output | 1 | Glitch-free system clock |
| sys_sel_q | output | 2 | System select readback |
| lp_sel_q | output | LP_W | Low-power select readback |
| xtal_off_q | output | 1 | Crystal-disable readback, also the disable to the oscillator |
| run_xtal | output | 1 | Crystal drives the system clock |
| run_rc | output | 1 | RC oscillator drives the system clock |
| run_lp | output | 1 | Low-power clock drives the system clock |

## Verification
Field readbacks are due one `clk` cycle after the write strobe. The bench drives the strobe on a falling edge and reads the field on the next falling edge. The status bits depend on source clocks that are unrelated to `clk`, so no exact cycle is fixed for them. The bench checks that they still show the old source three cycles after a select write, then waits 150 cycles, which exceeds the slowest two-handshake path, before comparing them with its model. After each settle, the bench times two rising edges of `sys_clk` to confirm the period of the source it expects. A monitor measures every high pulse of `sys_clk` over the whole run.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int SEL_W = 2;
  localparam int NSRC  = 3;
  localparam int IDX_XTAL = 0;
  localparam int IDX_RC   = 1;
  localparam int IDX_LP   = 2;
  localparam logic [SEL_W-1:0] SYS_SEL_RST = 2'd1;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_RC   = 2'd1,
    SRC_LP   = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    HS_RUN   = 2'd0,
    HS_BREAK = 2'd1,
    HS_MAKE  = 2'd2
  } hs_e;

  function automatic src_e sel_to_src(logic [SEL_W-1:0] s);
    if (s[1])      return SRC_LP;
    else if (s[0]) return SRC_RC;
    else           return SRC_XTAL;
  endfunction

  function automatic logic [NSRC-1:0] src_oh(src_e s);
    logic [NSRC-1:0] v;
    v = '0;
    v[int'(s)] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/sysclk_sync2.sv
module sysclk_sync2 #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sysclk_gate.sv
module sysclk_gate #(
  parameter bit RST_ON = 1'b0,
  parameter int STAGES = 2
) (
  input  logic clk_src,
  input  logic arst_n,
  input  logic en_req,
  output logic gclk,
  output logic en_state
);
  logic lrst_n;
  logic req_q;
  logic on_q;

  // local reset, released on the source's own clock
  sysclk_sync2 #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_rsync (
    .clk   (clk_src),
    .rst_n (arst_n),
    .d     (1'b1),
    .q     (lrst_n)
  );

  always_ff @(posedge clk_src or negedge lrst_n) begin
    if (!lrst_n) req_q <= RST_ON;
    else         req_q <= en_req;
  end

  // enable changes only while the source clock is low
  always_ff @(negedge clk_src or negedge lrst_n) begin
    if (!lrst_n) on_q <= RST_ON;
    else         on_q <= req_q;
  end

  assign gclk     = clk_src & on_q;
  assign en_state = on_q;
endmodule

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
#(
  parameter int LP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_din,
  input  logic             lpsel_we,
  input  logic [LP_W-1:0]  lpsel_din,
  input  logic             xoff_we,
  input  logic             xoff_din,
  input  logic             xtal_busy,
  input  logic             lp_busy,
  output logic [SEL_W-1:0] sys_sel_q,
  output logic [LP_W-1:0]  lp_sel_q,
  output logic             xoff_q
);
  logic             sel_en, lp_en, xoff_en;
  logic [SEL_W-1:0] sys_sel_d;
  logic [LP_W-1:0]  lp_sel_d;
  logic             xoff_d;

  always_comb begin
    sel_en  = sel_we;
    lp_en   = lpsel_we && !lp_busy;
    xoff_en = xoff_we && !(xoff_din && xtal_busy);
    sys_sel_d = sel_en  ? sel_din   : sys_sel_q;
    lp_sel_d  = lp_en   ? lpsel_din : lp_sel_q;
    xoff_d    = xoff_en ? xoff_din  : xoff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_sel_q <= SYS_SEL_RST;
      lp_sel_q  <= '0;
      xoff_q    <= 1'b0;
    end else begin
      sys_sel_q <= sys_sel_d;
      lp_sel_q  <= lp_sel_d;
      xoff_q    <= xoff_d;
    end
  end
endmodule

// File: rtl/sysclk_fsm.sv
module sysclk_fsm
  import sysclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  src_e            want,
  input  logic            xtal_ready,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] en_req,
  output logic [NSRC-1:0] run,
  output logic            xtal_busy,
  output logic            lp_busy
);
  hs_e             st_q, st_d;
  src_e            cur_q, cur_d;
  src_e            tgt_q, tgt_d;
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] run_q, run_d;
  logic            go;

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    tgt_d = tgt_q;
    en_d  = en_q;
    run_d = run_q;
    go    = (want != cur_q) && ((want != SRC_XTAL) || xtal_ready);
    case (st_q)
      HS_RUN: begin
        if (go) begin
          tgt_d = want;
          en_d  = en_q & ~src_oh(cur_q);
          st_d  = HS_BREAK;
        end
      end
      HS_BREAK: begin
        if (ack == '0) begin
          en_d = src_oh(tgt_q);
          st_d = HS_MAKE;
        end
      end
      HS_MAKE: begin
        if ((ack & src_oh(tgt_q)) != '0) begin
          cur_d = tgt_q;
          run_d = src_oh(tgt_q);
          st_d  = HS_RUN;
        end
      end
      default: st_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HS_RUN;
      cur_q <= SRC_RC;
      tgt_q <= SRC_RC;
      en_q  <= src_oh(SRC_RC);
      run_q <= src_oh(SRC_RC);
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      tgt_q <= tgt_d;
      en_q  <= en_d;
      run_q <= run_d;
    end
  end

  assign en_req    = en_q;
  assign run       = run_q;
  assign xtal_busy = run_q[IDX_XTAL] || ((st_q != HS_RUN) && (tgt_q == SRC_XTAL));
  assign lp_busy   = run_q[IDX_LP]   || ((st_q != HS_RUN) && (tgt_q == SRC_LP));
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import sysclk_pkg::*;
#(
  parameter int LP_W   = 2,
  parameter int STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_we,
  input  logic [1:0]             sel_din,
  input  logic                   lpsel_we,
  input  logic [LP_W-1:0]        lpsel_din,
  input  logic                   xoff_we,
  input  logic                   xoff_din,
  input  logic                   xtal_settled,
  input  logic                   xtal_trim_rdy,
  input  logic                   clk_xtal,
  input  logic                   clk_rc,
  input  logic [(1<<LP_W)-1:0]   clk_lp_src,
  output logic                   sys_clk,
  output logic [1:0]             sys_sel_q,
  output logic [LP_W-1:0]        lp_sel_q,
  output logic                   xtal_off_q,
  output logic                   run_xtal,
  output logic                   run_rc,
  output logic                   run_lp
);
  logic            rst_s_n;
  logic [1:0]      flag_s;
  logic            xtal_ready;
  logic            xtal_busy, lp_busy;
  logic            lp_clk;
  logic [NSRC-1:0] src_clk;
  logic [NSRC-1:0] en_req;
  logic [NSRC-1:0] gstate;
  logic [NSRC-1:0] gclk;
  logic [NSRC-1:0] ack;
  logic [NSRC-1:0] run;

  sysclk_sync2 #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n)
  );

  sysclk_sync2 #(.W(2), .STAGES(STAGES), .RST_VAL(2'b00)) u_flag_sync (
    .clk(clk), .rst_n(rst_s_n), .d({xtal_settled, xtal_trim_rdy}), .q(flag_s)
  );

  sysclk_sync2 #(.W(NSRC), .STAGES(STAGES), .RST_VAL('0)) u_ack_sync (
    .clk(clk), .rst_n(rst_s_n), .d(gstate), .q(ack)
  );

  sysclk_regs #(.LP_W(LP_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .sel_we(sel_we), .sel_din(sel_din),
    .lpsel_we(lpsel_we), .lpsel_din(lpsel_din),
    .xoff_we(xoff_we), .xoff_din(xoff_din),
    .xtal_busy(xtal_busy), .lp_busy(lp_busy),
    .sys_sel_q(sys_sel_q), .lp_sel_q(lp_sel_q), .xoff_q(xtal_off_q)
  );

  assign xtal_ready = (|flag_s) && !xtal_off_q;

  sysclk_fsm u_fsm (
    .clk(clk), .rst_n(rst_s_n),
    .want(sel_to_src(sys_sel_q)), .xtal_ready(xtal_ready), .ack(ack),
    .en_req(en_req), .run(run), .xtal_busy(xtal_busy), .lp_busy(lp_busy)
  );

  // low-power select only moves while this leg is closed
  assign lp_clk = clk_lp_src[lp_sel_q];

  assign src_clk[IDX_XTAL] = clk_xtal;
  assign src_clk[IDX_RC]   = clk_rc;
  assign src_clk[IDX_LP]   = lp_clk;

  for (genvar g = 0; g < NSRC; g++) begin : g_leg
    sysclk_gate #(.RST_ON(g == IDX_RC), .STAGES(STAGES)) u_gate (
      .clk_src (src_clk[g]),
      .arst_n  (rst_n),
      .en_req  (en_req[g]),
      .gclk    (gclk[g]),
      .en_state(gstate[g])
    );
  end

  assign sys_clk  = |gclk;
  assign run_xtal = run[IDX_XTAL];
  assign run_rc   = run[IDX_RC];
  assign run_lp   = run[IDX_LP];
endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk #(
  parameter int LP_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sel_we,
  input logic [1:0]      sel_din,
  input logic            lpsel_we,
  input logic            xoff_we,
  input logic            xoff_din,
  input logic [1:0]      sys_sel_q,
  input logic [LP_W-1:0] lp_sel_q,
  input logic            xtal_off_q,
  input logic            run_xtal,
  input logic            run_rc,
  input logic            run_lp,
  input logic [2:0]      gate_state
);
  p_sel_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> (sys_sel_q == $past(sel_din)));

  p_run_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({run_lp, run_rc, run_xtal}) == 1);

  p_bbm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate_state) <= 1);

  p_xtal_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_xtal) |-> !xtal_off_q);

  p_xoff_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_we && xoff_din && run_xtal) |=> $stable(xtal_off_q));

  p_lp_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lpsel_we && run_lp) |=> $stable(lp_sel_q));
endmodule

bind sysclk_switch sysclk_switch_chk #(.LP_W(LP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_din(sel_din),
  .lpsel_we(lpsel_we), .xoff_we(xoff_we), .xoff_din(xoff_din),
  .sys_sel_q(sys_sel_q), .lp_sel_q(lp_sel_q), .xtal_off_q(xtal_off_q),
  .run_xtal(run_xtal), .run_rc(run_rc), .run_lp(run_lp),
  .gate_state(gstate)
);

// File: tb/sysclk_switch_tb_top.sv
`timescale 1ns/1ps
module sysclk_switch_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       clk_xtal = 1'b0, clk_rc = 1'b0;
  logic [3:0] clk_lp_src = 4'b0;
  logic       sel_we = 1'b0, lpsel_we = 1'b0, xoff_we = 1'b0, xoff_din = 1'b0;
  logic [1:0] sel_din = 2'd0, lpsel_din = 2'd0;
  logic       xtal_settled = 1'b0, xtal_trim_rdy = 1'b0;
  logic       sys_clk, xtal_off_q, run_xtal, run_rc, run_lp;
  logic [1:0] sys_sel_q, lp_sel_q;

  int n_chk = 0, n_bad = 0, n_runt = 0;
  int m_sel = 1, m_lp = 0, m_xoff = 0, m_cur = 1;
  real t_rise = -100.0;

  always #4  clk = ~clk;
  always #3  clk_xtal = ~clk_xtal;
  always #5  clk_rc = ~clk_rc;
  always #30 clk_lp_src[0] = ~clk_lp_src[0];
  always #35 clk_lp_src[1] = ~clk_lp_src[1];
  always #40 clk_lp_src[2] = ~clk_lp_src[2];
  always #45 clk_lp_src[3] = ~clk_lp_src[3];

  sysclk_switch dut_i (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_din(sel_din),
    .lpsel_we(lpsel_we), .lpsel_din(lpsel_din), .xoff_we(xoff_we), .xoff_din(xoff_din),
    .xtal_settled(xtal_settled), .xtal_trim_rdy(xtal_trim_rdy),
    .clk_xtal(clk_xtal), .clk_rc(clk_rc), .clk_lp_src(clk_lp_src),
    .sys_clk(sys_clk), .sys_sel_q(sys_sel_q), .lp_sel_q(lp_sel_q), .xtal_off_q(xtal_off_q),
    .run_xtal(run_xtal), .run_rc(run_rc), .run_lp(run_lp)
  );

  // R8 runt monitor: no high pulse below the shortest half period (3 ns)
  always @(posedge sys_clk) t_rise = $realtime;
  always @(negedge sys_clk) if ($realtime - t_rise < 2.9) n_runt++;

  function automatic int want_of(int s);
    return (s >= 2) ? 2 : s;
  endfunction

  function automatic int per_ps(int src, int lp);
    if (src == 0) return 6000;
    if (src == 1) return 10000;
    return 60000 + lp * 10000;
  endfunction

  function automatic int oh(int s);
    return 1 << s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int run_vec();
    return {29'd0, run_lp, run_rc, run_xtal};
  endfunction

  task automatic wr_sel(input int v);
    @(negedge clk); sel_we = 1'b1; sel_din = 2'(v);
    @(negedge clk); sel_we = 1'b0;
    m_sel = v;
  endtask

  task automatic wr_lp(input int v);
    @(negedge clk); lpsel_we = 1'b1; lpsel_din = 2'(v);
    @(negedge clk); lpsel_we = 1'b0;
    if (m_cur != 2) m_lp = v;
  endtask

  task automatic wr_xoff(input int v);
    @(negedge clk); xoff_we = 1'b1; xoff_din = v[0];
    @(negedge clk); xoff_we = 1'b0;
    if (!(v == 1 && m_cur == 0)) m_xoff = v;
  endtask

  task automatic set_flags(input bit s, input bit t);
    @(negedge clk); xtal_settled = s; xtal_trim_rdy = t;
  endtask

  task automatic check_regs(input string req);
    chk(sys_sel_q == 2'(m_sel), req, "sys_sel_q", int'(sys_sel_q), m_sel);
    chk(lp_sel_q == 2'(m_lp), req, "lp_sel_q", int'(lp_sel_q), m_lp);
    chk(xtal_off_q == m_xoff[0], req, "xtal_off_q", int'(xtal_off_q), m_xoff);
  endtask

  task automatic measure(output int ps);
    real t0, t1;
    @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk); t1 = $realtime;
    ps = $rtoi((t1 - t0) * 1000.0 + 0.5);
    @(negedge clk);
  endtask

  task automatic settle(input string req);
    int w, ps;
    bit rdy;
    w = want_of(m_sel);
    rdy = (xtal_settled || xtal_trim_rdy) && (m_xoff == 0);
    if (w != m_cur && (w != 0 || rdy)) m_cur = w;
    repeat (150) @(negedge clk);
    chk(run_vec() == oh(m_cur), req, "run status", run_vec(), oh(m_cur));
    measure(ps);
    chk(ps == per_ps(m_cur, m_lp), req, "sys_clk period ps", ps, per_ps(m_cur, m_lp));
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R1 reset state
    check_regs("R1");
    chk(run_vec() == 2, "R1", "run status", run_vec(), 2);
    settle("R2");

    // R4 crystal held off while neither flag is set
    wr_sel(0);
    check_regs("R9");
    settle("R4");
    set_flags(1'b0, 1'b1);
    settle("R4");

    // R5 disable write ignored while the crystal runs
    wr_xoff(1);
    check_regs("R5");

    // R7 status holds through the handshake, then R3 low-power source 0
    wr_sel(2);
    repeat (2) @(negedge clk);
    chk(run_vec() == 1, "R7", "status during handshake", run_vec(), 1);
    settle("R3");

    // R6 low-power select locked while in use
    wr_lp(3);
    check_regs("R6");
    settle("R6");

    // back to RC, change the low-power source, use it through select 3
    wr_sel(1);
    settle("R2");
    wr_lp(3);
    check_regs("R6");
    wr_sel(3);
    settle("R3");

    // R10 selection changed in mid-handshake
    wr_sel(0);
    wr_sel(1);
    settle("R10");

    // R4 disabled crystal stays off even with flags
    wr_xoff(1);
    check_regs("R5");
    wr_sel(0);
    settle("R4");
    wr_xoff(0);
    settle("R4");

    // random mix
    for (int i = 0; i < 40; i++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: wr_sel(int'($urandom % 4));
        1: wr_lp(int'($urandom % 4));
        2: wr_xoff(int'($urandom % 2));
        3: set_flags(1'($urandom % 2), xtal_trim_rdy);
        default: set_flags(xtal_settled, 1'($urandom % 2));
      endcase
      check_regs("R9");
      settle("R2");
    end

    chk(n_runt == 0, "R8", "runt pulses", n_runt, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule